// File: doc/BRIEF.md
# GPIO Input Debouncer

This block cleans up to 32 asynchronous GPIO input lines before they reach the input port and the interrupt logic of a GPIO bank. Every line first crosses into the bus clock domain through a two-flop synchronizer. Each line then either passes through unchanged or goes through a glitch filter. The filter accepts a new level only after that level is seen on two sample ticks in a row.

A filtered line takes one of two sample rates. It can sample on every bus clock, which rejects single-clock glitches. It can instead sample on a slower tick made by one 24-bit reload divider that all lines of the bank share. With a reload value of V, the tick repeats every V + 1 clocks, so the filter time is (V + 1) × 2 clock periods. A write of a new reload value restarts the divider count from zero.

Top module: `gpio_debounce_bank`

## Requirements
- R1: Each input passes through a two-flop synchronizer. For a line in bypass, a change on `pin_in[i]` appears on `pin_out[i]` after exactly two rising clock edges.
- R2: When `db_en[i]` is 0, `pin_out[i]` equals the synchronized input with no added delay, and a one-clock pulse passes through.
- R3: When `db_en[i]` is 1 and `div_sel[i]` is 0, the line is sampled on every clock. A synchronized level that lasts a single clock never reaches `pin_out[i]`. A held change appears two clocks after it leaves the synchronizer, which is four edges after the input changes.
- R4: When `db_en[i]` is 1 and `div_sel[i]` is 1, the line is sampled only on the shared divider tick. A level that is not seen on two consecutive ticks is rejected, and between ticks the filtered output holds its value.
- R5: With reload value V, the divider ticks once every V + 1 clocks. A held change on a divided line reaches the output between V + 4 and 2·V + 4 rising edges after the input changes.
- R6: A pulse on `div_wr` loads `div_value` and restarts the count from zero, so the first tick after the load comes V + 1 edges after the load edge. The reload value resets to 0, so after reset a divided line behaves like a line sampled on every clock.
- R7: The divider is shared. Divided lines that see the same input change update `pin_out` on the same clock.
- R8: While `rst_n` is low, all outputs are 0 and all filter state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_in | input | 32 | Raw asynchronous GPIO input levels |
| db_en | input | 32 | Per-line filter enable (0 = bypass) |
| div_sel | input | 32 | Per-line sample rate select (1 = divider tick, 0 = every clock) |
| div_wr | input | 1 | One-clock strobe that loads `div_value` into the divider |
| div_value | input | 24 | Divider reload value V |
| pin_out | output | 32 | Synchronized and optionally filtered levels |

## Verification
The bench builds the block with its default 32 lines and 24-bit divider. It then programs reload values of 0, 5 and 2, so that several full tick periods and both filter stages fit into a few dozen clocks. Lines 0–7 are set to bypass, lines 8–15 to every-clock sampling and lines 16–31 to the divided tick. This puts all three modes side by side under the same random stimulus. Exact edge counts are checked for the synchronizer, for the every-clock filter and for the restart after a reload write. The arbitrary-phase latency of a divided line is checked against its window.

// File: rtl/gdb_pkg.sv
`timescale 1ns/1ps
package gdb_pkg;

  typedef enum logic [1:0] {
    DB_PASS = 2'd0,
    DB_FAST = 2'd1,
    DB_DIV  = 2'd2
  } db_mode_e;

  function automatic db_mode_e pick_mode(input logic en, input logic sel);
    if (!en)     return DB_PASS;
    else if (sel) return DB_DIV;
    else          return DB_FAST;
  endfunction

endpackage

// File: rtl/gdb_sync.sv
`timescale 1ns/1ps
module gdb_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gdb_tick_div.sv
`timescale 1ns/1ps
module gdb_tick_div #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] value_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cfg_q, cfg_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap   = (cnt_q == cfg_q);
    tick_o = wrap && !wr_i;
    cfg_d  = cfg_q;
    cnt_d  = cnt_q + DIV_W'(1);
    if (wr_i) begin
      cfg_d = value_i;
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: a nonzero reload value never yields two ticks in adjacent cycles
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && cfg_q != '0 && !wr_i) |=> !tick_o);

  // R5: the count never runs past the reload value
  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cfg_q);

  // R6: right after a load, a tick appears only if the new value is zero
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (!tick_o || cfg_q == '0 || wr_i));

endmodule

// File: rtl/gdb_filter_cell.sv
`timescale 1ns/1ps
module gdb_filter_cell
  import gdb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic en_i,
  input  logic sel_i,
  input  logic tick_div_i,
  output logic out_o
);

  db_mode_e mode;
  logic     smp;
  logic     filt_q, filt_d;
  logic     pend_q, pend_d;

  always_comb begin
    mode   = pick_mode(en_i, sel_i);
    smp    = (mode == DB_DIV) ? tick_div_i : 1'b1;
    filt_d = filt_q;
    pend_d = pend_q;
    case (mode)
      DB_PASS: begin
        filt_d = raw_i;
        pend_d = 1'b0;
      end
      default: begin
        if (smp) begin
          if (raw_i != filt_q) begin
            if (pend_q) begin
              filt_d = raw_i;
              pend_d = 1'b0;
            end else begin
              pend_d = 1'b1;
            end
          end else begin
            pend_d = 1'b0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      filt_q <= filt_d;
      pend_q <= pend_d;
    end
  end

  assign out_o = (mode == DB_PASS) ? raw_i : filt_q;

  // R4: an enabled filter holds its level between sample ticks
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !smp) |=> $stable(filt_q));

  // R3: the first differing sample only arms the filter
  p_first_sample_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !pend_q) |=> $stable(filt_q));

endmodule

// File: rtl/gpio_debounce_bank.sv
`timescale 1ns/1ps
module gpio_debounce_bank #(
  parameter int NUM_PINS    = 32,
  parameter int DIV_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] db_en,
  input  logic [NUM_PINS-1:0] div_sel,
  input  logic                div_wr,
  input  logic [DIV_W-1:0]    div_value,
  output logic [NUM_PINS-1:0] pin_out
);

  localparam int LAST_PIN = NUM_PINS - 1;

  logic [LAST_PIN:0] sync_lvl;
  logic              div_tick;

  gdb_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_in),
    .q_o  (sync_lvl)
  );

  gdb_tick_div #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (div_wr),
    .value_i(div_value),
    .tick_o (div_tick)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gdb_filter_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (sync_lvl[i]),
      .en_i      (db_en[i]),
      .sel_i     (div_sel[i]),
      .tick_div_i(div_tick),
      .out_o     (pin_out[i])
    );
  end

  // R8: outputs come out of reset cleared
  p_reset_clear_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_out & db_en) == '0);

endmodule

// File: tb/sim_gpio_debounce_bank.sv
`timescale 1ns/1ps
module sim_gpio_debounce_bank;

  localparam int NP = 32;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_in, db_en, div_sel;
  logic          div_wr;
  logic [DW-1:0] div_value;
  logic [NP-1:0] pin_out;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  gpio_debounce_bank u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .db_en(db_en),
    .div_sel(div_sel), .div_wr(div_wr), .div_value(div_value),
    .pin_out(pin_out)
  );

  // behavioural reference
  bit [NP-1:0] m_s1, m_s2, m_out, m_pend;
  int          m_cnt, m_cfg;
  bit          m_tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_out = '0; m_pend = '0;
      m_cnt = 0; m_cfg = 0;
    end else begin
      m_tick = (m_cnt == m_cfg) && !div_wr;
      for (int i = 0; i < NP; i++) begin
        if (!db_en[i]) begin
          m_out[i] = m_s2[i]; m_pend[i] = 0;
        end else if (!div_sel[i] || m_tick) begin
          if (m_s2[i] != m_out[i]) begin
            if (m_pend[i]) begin m_out[i] = m_s2[i]; m_pend[i] = 0; end
            else m_pend[i] = 1;
          end else m_pend[i] = 0;
        end
      end
      if (div_wr) begin m_cfg = int'(div_value); m_cnt = 0; end
      else if (m_cnt == m_cfg) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [NP-1:0] exp_v;
      exp_v = (db_en & m_out) | (~db_en & m_s2);
      checks++;
      if (pin_out !== exp_v) begin
        int bad;
        bad = 0;
        for (int i = NP-1; i >= 0; i--) if (pin_out[i] !== exp_v[i]) bad = i;
        errors++;
        $display("FAIL %s model compare pin %0d actual=%h expected=%h",
                 !db_en[bad] ? "R2" : (!div_sel[bad] ? "R3" : "R4"),
                 bad, pin_out, exp_v);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic drv_edge();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    finish_run();
  end

  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic rand_phase(input int n);
    for (int k = 0; k < n; k++) begin
      drv_edge();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pin_in = pin_in ^ (lfsr & (lfsr >> 3) & (lfsr >> 7));
      if (k == n/2) db_en = db_en ^ 32'h0000_3C3C;
    end
  endtask

  initial begin
    rst_n = 0; pin_in = '0; db_en = '0; div_sel = '0; div_wr = 0; div_value = '0;
    pin_in = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 outputs cleared in reset", pin_out, 32'h0);
    drv_edge();
    pin_in = '0;
    db_en = 32'hFFFF_FF00; div_sel = 32'hFFFF_0000;
    rst_n = 1;
    repeat (4) drv_edge();
    cmp_on = 1;

    // R1: bypass line latency is two edges
    pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 pin0 after one edge", pin_out[0], 0);
    @(negedge clk);
    chk("R1 pin0 after two edges", pin_out[0], 1);

    // R2: one-clock pulse passes a bypass line
    drv_edge(); pin_in[1] = 1'b1;
    drv_edge(); pin_in[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 pulse visible", pin_out[1], 1);
    @(negedge clk);
    chk("R2 pulse ends", pin_out[1], 0);

    // R3: one-clock pulse rejected on a fast-filtered line
    begin
      logic seen;
      seen = 0;
      drv_edge(); pin_in[8] = 1'b1;
      drv_edge(); pin_in[8] = 1'b0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); seen |= pin_out[8]; end
      chk("R3 glitch rejected", seen, 0);
    end

    // R3 and R6: held change on fast line and on divided line after reset value 0
    drv_edge(); pin_in[9] = 1'b1; pin_in[16] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 pin9 before 4 edges", pin_out[9], 0);
    chk("R6 pin16 reset value acts as every clock (before)", pin_out[16], 0);
    @(negedge clk);
    chk("R3 pin9 at 4 edges", pin_out[9], 1);
    chk("R6 pin16 reset value acts as every clock (at)", pin_out[16], 1);

    rand_phase(200);
    drv_edge(); pin_in = '0;
    repeat (8) drv_edge();

    // R6: load V=5 together with an input change, exact timing
    div_wr = 1; div_value = 24'd5; pin_in[19:17] = 3'b111;
    @(negedge clk);
    drv_edge(); div_wr = 0;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      chk("R7 shared tick pin18 vs pin17", pin_out[18], pin_out[17]);
      chk("R7 shared tick pin19 vs pin17", pin_out[19], pin_out[17]);
      if (k == 12) chk("R6 restart pin17 before edge 13", pin_out[17], 0);
      if (k == 13) chk("R6 restart pin17 at edge 13", pin_out[17], 1);
    end

    // R4: one-clock pulse on a divided line rejected
    begin
      logic seen;
      seen = 0;
      drv_edge(); pin_in[20] = 1'b1;
      drv_edge(); pin_in[20] = 1'b0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); seen |= pin_out[20]; end
      chk("R4 divided glitch rejected", seen, 0);
    end

    // R5: latency window at arbitrary phase, V=5 -> 9..14 edges
    repeat (3) drv_edge();
    pin_in[21] = 1'b1;
    begin
      int lat;
      lat = 0;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (lat == 0 && pin_out[21]) lat = k;
      end
      checks++;
      if (lat < 9 || lat > 14) begin
        errors++;
        $display("FAIL R5 latency actual=%0d expected=9..14", lat);
      end
    end

    drv_edge(); div_wr = 1; div_value = 24'd2;
    drv_edge(); div_wr = 0;
    rand_phase(300);
    repeat (10) drv_edge();
    finish_run();
  end

endmodule